// File: doc/BRIEF.md
# Software-Refilled Fully Associative Address Translation Buffer

This block translates 32-bit virtual addresses to 32-bit physical addresses for 4 KiB pages. It holds sixteen translations in a fully associative array and serves instruction fetches and data accesses alike. A lookup returns its result combinationally in the same cycle. The physical address is the matched physical page number followed by the untranslated 12-bit page offset.

The hardware never refills the array. A lookup that finds no valid matching entry raises a miss exception. A write access that hits a clean page raises a modify exception. In both cases the faulting virtual page number is latched into a register, so that a handler can walk the page table, then install or update the entry. Entries are written through a separate port that only accepts supervisor-mode requests. That port can install one entry, invalidate one entry or clear every entry at once. A request from user mode is refused and reported as a privilege fault.

Top module: `tlb_sw_refill`

## Requirements
- R1: When `lookupValid` is 1 and a valid entry's virtual page tag equals `lookupVaddr[31:12]`, `hit` is 1 in the same cycle and `paddr` equals that entry's physical page number concatenated with `lookupVaddr[11:0]`.
- R2: When `lookupValid` is 1 and no valid entry matches, `missExc` is 1 and `hit` is 0 in the same cycle.
- R3: In a cycle with `missExc` or `modifyExc` set, the clock edge loads `lookupVaddr[31:12]` into `faultVpn` and sets `faultPending`. The value is held until a later fault overwrites it or `faultRead` is sampled high, which clears both to 0. A fault in the same cycle as `faultRead` takes priority.
- R4: A write lookup (`lookupWrite`=1) that hits an entry whose dirty bit is 0 sets `modifyExc` while `hit` stays 1. A read hit, or a write hit on a dirty entry, leaves `modifyExc` at 0.
- R5: When several valid entries match, the lowest-index entry supplies `paddr` and dirty status, and `multiHit` is 1. With one match or none, `multiHit` is 0.
- R6: A supervisor request on the entry port takes effect at the clock edge and is visible to lookups from the next cycle. `wrOp` codes: 0 installs {`wrVpn`, `wrPpn`, `wrDirty`, valid=1} at `wrIndex`. 1 clears the valid bit of entry `wrIndex`. 2 clears every valid bit in one cycle. 3 does nothing.
- R7: An entry-port request with `wrSupervisor`=0 changes no entry, and `privFault` is 1 for exactly the cycle after it. Otherwise `privFault` is 0.
- R8: After reset no entry is valid, and `faultVpn`, `faultPending` and `privFault` are 0.
- R9: With `lookupValid` at 0, `hit`, `missExc`, `modifyExc` and `multiHit` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Translation request present |
| lookupVaddr | input | 32 | Virtual address to translate |
| lookupWrite | input | 1 | 1 for a write access, 0 for a read or fetch |
| hit | output | 1 | A valid entry matched |
| paddr | output | 32 | Translated physical address |
| missExc | output | 1 | No valid translation |
| modifyExc | output | 1 | Write hit on a clean page |
| multiHit | output | 1 | More than one valid entry matched |
| faultVpn | output | 20 | Latched faulting virtual page number |
| faultPending | output | 1 | `faultVpn` holds an unread fault |
| faultRead | input | 1 | Software has read `faultVpn`; clears it |
| wrValid | input | 1 | Entry-port request |
| wrSupervisor | input | 1 | Requester is in supervisor mode |
| wrOp | input | 2 | 0 install, 1 invalidate one, 2 invalidate all, 3 none |
| wrIndex | input | 4 | Entry index for install or invalidate |
| wrVpn | input | 20 | Virtual page tag to install |
| wrPpn | input | 20 | Physical page number to install |
| wrDirty | input | 1 | Dirty bit to install |
| privFault | output | 1 | Entry-port request refused, one cycle after it |

## Verification
The assertions check on every cycle that hit and miss exclude each other and that a modify exception only comes with a write hit. They also check that the page offset passes through untranslated and that a multi-hit implies a hit. Each fault must land in the fault register one edge later, a read must clear it, and a user-mode request must produce a privilege fault in the following cycle. Only the bench scenarios can show the actual mappings. These include the lowest-index choice among duplicate tags, the effect of single and global invalidation, and the fact that a refused user write leaves the array untouched.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int VA_W       = 32;
  parameter int PA_W       = 32;
  parameter int OFS_W      = 12;
  parameter int NUM_ENTRY  = 16;
  parameter int ENTRY_W    = 64;
  localparam int VPN_W     = VA_W - OFS_W;
  localparam int PPN_W     = PA_W - OFS_W;
  localparam int IDX_W     = $clog2(NUM_ENTRY);
  localparam int SPARE_W   = ENTRY_W - 2 - VPN_W - PPN_W;

  typedef enum logic [1:0] {
    OP_INSTALL = 2'd0,
    OP_INV_ONE = 2'd1,
    OP_INV_ALL = 2'd2,
    OP_NONE    = 2'd3
  } wrOp_e;

  typedef struct packed {
    logic               valid;
    logic               dirty;
    logic [SPARE_W-1:0] spare;
    logic [PPN_W-1:0]   ppn;
    logic [VPN_W-1:0]   vpn;
  } tlbEntry_t;

  typedef struct packed {
    logic             installEn;
    logic             invOneEn;
    logic             invAllEn;
    logic [IDX_W-1:0] index;
    logic             latchFault;
    logic             clearFault;
  } tlbStrobe_t;
endpackage

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  tlbStrobe_t       strb,
  input  logic [VPN_W-1:0] wrVpn,
  input  logic [PPN_W-1:0] wrPpn,
  input  logic             wrDirty,
  input  logic [VPN_W-1:0] lookupVpn,
  output logic             hitAny,
  output logic             hitDirty,
  output logic [PPN_W-1:0] hitPpn,
  output logic             multiMatch,
  output logic [VPN_W-1:0] faultVpn,
  output logic             faultPending
);
  tlbEntry_t            entryQ [NUM_ENTRY];
  logic [NUM_ENTRY-1:0] matchVec;
  logic [IDX_W-1:0]     selIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENTRY; i++) entryQ[i] <= '0;
    end else if (strb.invAllEn) begin
      for (int i = 0; i < NUM_ENTRY; i++) entryQ[i].valid <= 1'b0;
    end else if (strb.installEn) begin
      entryQ[strb.index] <= '{valid: 1'b1, dirty: wrDirty, spare: '0,
                              ppn: wrPpn, vpn: wrVpn};
    end else if (strb.invOneEn) begin
      entryQ[strb.index].valid <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_ENTRY; g++) begin : gMatch
    assign matchVec[g] = entryQ[g].valid && (entryQ[g].vpn == lookupVpn);
  end

  always_comb begin
    selIdx = '0;
    for (int i = NUM_ENTRY - 1; i >= 0; i--) begin
      if (matchVec[i]) selIdx = IDX_W'(i);
    end
  end

  assign hitAny     = |matchVec;
  assign multiMatch = |(matchVec & (matchVec - NUM_ENTRY'(1)));
  assign hitPpn     = entryQ[selIdx].ppn;
  assign hitDirty   = entryQ[selIdx].dirty;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultVpn     <= '0;
      faultPending <= 1'b0;
    end else if (strb.latchFault) begin
      faultVpn     <= lookupVpn;
      faultPending <= 1'b1;
    end else if (strb.clearFault) begin
      faultVpn     <= '0;
      faultPending <= 1'b0;
    end
  end
endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic             lookupWrite,
  input  logic             hitAny,
  input  logic             hitDirty,
  input  logic             multiMatch,
  input  logic             faultRead,
  input  logic             wrValid,
  input  logic             wrSupervisor,
  input  logic [1:0]       wrOp,
  input  logic [IDX_W-1:0] wrIndex,
  output tlbStrobe_t       strb,
  output logic             hit,
  output logic             missExc,
  output logic             modifyExc,
  output logic             multiHit,
  output logic             privFault
);
  logic  wrAllowed;
  wrOp_e opDec;

  assign opDec     = wrOp_e'(wrOp);
  assign wrAllowed = wrValid && wrSupervisor;

  assign hit       = lookupValid && hitAny;
  assign missExc   = lookupValid && !hitAny;
  assign modifyExc = hit && lookupWrite && !hitDirty;
  assign multiHit  = hit && multiMatch;

  always_comb begin
    strb            = '0;
    strb.index      = wrIndex;
    strb.installEn  = wrAllowed && (opDec == OP_INSTALL);
    strb.invOneEn   = wrAllowed && (opDec == OP_INV_ONE);
    strb.invAllEn   = wrAllowed && (opDec == OP_INV_ALL);
    strb.latchFault = missExc || modifyExc;
    strb.clearFault = faultRead;
  end

  always_ff @(posedge clk) begin
    if (!rstN) privFault <= 1'b0;
    else       privFault <= wrValid && !wrSupervisor;
  end
endmodule

// File: rtl/tlb_sw_refill.sv
module tlb_sw_refill
  import tlb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic [VA_W-1:0]  lookupVaddr,
  input  logic             lookupWrite,
  output logic             hit,
  output logic [PA_W-1:0]  paddr,
  output logic             missExc,
  output logic             modifyExc,
  output logic             multiHit,
  output logic [VPN_W-1:0] faultVpn,
  output logic             faultPending,
  input  logic             faultRead,
  input  logic             wrValid,
  input  logic             wrSupervisor,
  input  logic [1:0]       wrOp,
  input  logic [IDX_W-1:0] wrIndex,
  input  logic [VPN_W-1:0] wrVpn,
  input  logic [PPN_W-1:0] wrPpn,
  input  logic             wrDirty,
  output logic             privFault
);
  tlbStrobe_t       strb;
  logic             hitAny, hitDirty, multiMatch;
  logic [PPN_W-1:0] hitPpn;

  tlb_ctrl u_ctrl (
    .clk, .rstN, .lookupValid, .lookupWrite, .hitAny, .hitDirty, .multiMatch,
    .faultRead, .wrValid, .wrSupervisor, .wrOp, .wrIndex, .strb, .hit,
    .missExc, .modifyExc, .multiHit, .privFault
  );

  tlb_datapath u_dp (
    .clk, .rstN, .strb, .wrVpn, .wrPpn, .wrDirty,
    .lookupVpn(lookupVaddr[VA_W-1:OFS_W]), .hitAny, .hitDirty, .hitPpn,
    .multiMatch, .faultVpn, .faultPending
  );

  assign paddr = {hitPpn, lookupVaddr[OFS_W-1:0]};
endmodule

// File: rtl/tlb_sva.sv
module tlb_sva
  import tlb_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             lookupValid,
  input logic [VA_W-1:0]  lookupVaddr,
  input logic             lookupWrite,
  input logic             hit,
  input logic [PA_W-1:0]  paddr,
  input logic             missExc,
  input logic             modifyExc,
  input logic             multiHit,
  input logic [VPN_W-1:0] faultVpn,
  input logic             faultPending,
  input logic             faultRead,
  input logic             wrValid,
  input logic             wrSupervisor,
  input logic             privFault
);
  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rstN) !(hit && missExc)); // R2
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rstN) hit |-> paddr[OFS_W-1:0] == lookupVaddr[OFS_W-1:0]); // R1
  AST_MODIFY_ON_WRITE_HIT: assert property (@(posedge clk) disable iff (!rstN) modifyExc |-> (hit && lookupWrite)); // R4
  AST_MULTI_IS_HIT: assert property (@(posedge clk) disable iff (!rstN) multiHit |-> hit); // R5
  AST_FAULT_LATCH: assert property (@(posedge clk) disable iff (!rstN) (missExc || modifyExc) |=> (faultPending && faultVpn == $past(lookupVaddr[VA_W-1:OFS_W]))); // R3
  AST_FAULT_CLEAR: assert property (@(posedge clk) disable iff (!rstN) (faultRead && !missExc && !modifyExc) |=> (!faultPending && faultVpn == '0)); // R3
  AST_PRIV_FAULT: assert property (@(posedge clk) disable iff (!rstN) (wrValid && !wrSupervisor) |=> privFault); // R7
  AST_PRIV_QUIET: assert property (@(posedge clk) disable iff (!rstN) !(wrValid && !wrSupervisor) |=> !privFault); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN) !lookupValid |-> !(hit || missExc || modifyExc || multiHit)); // R9
endmodule

bind tlb_sw_refill tlb_sva u_sva (
  .clk, .rstN, .lookupValid, .lookupVaddr, .lookupWrite, .hit, .paddr,
  .missExc, .modifyExc, .multiHit, .faultVpn, .faultPending, .faultRead,
  .wrValid, .wrSupervisor, .privFault
);

// File: tb/tb_tlb_sw_refill.sv
module tb_tlb_sw_refill;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {vaddr, write, expHit, expMiss, expMod, expMulti, expPaddr}
  localparam logic [68:0] VEC [NVEC] = '{
    {32'h0001_0123, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0ABC_D123},
    {32'h1234_5FFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h5432_1FFF},
    {32'h1234_5000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 32'h5432_1000},
    {32'hFFFF_F800, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_1800},
    {32'h0002_0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0000},
    {32'h0001_0004, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0ABC_D004}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic lookupValid = 1'b0, lookupWrite = 1'b0, faultRead = 1'b0;
  logic [31:0] lookupVaddr = '0;
  logic wrValid = 1'b0, wrSupervisor = 1'b0, wrDirty = 1'b0;
  logic [1:0] wrOp = 2'd3;
  logic [3:0] wrIndex = '0;
  logic [19:0] wrVpn = '0, wrPpn = '0;
  logic hit, missExc, modifyExc, multiHit, faultPending, privFault;
  logic [31:0] paddr;
  logic [19:0] faultVpn;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_sw_refill dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic entryOp(input logic sup, input logic [1:0] op, input logic [3:0] idx,
                         input logic [19:0] vpn, input logic [19:0] ppn, input logic d);
    wrValid = 1'b1; wrSupervisor = sup; wrOp = op; wrIndex = idx;
    wrVpn = vpn; wrPpn = ppn; wrDirty = d;
    tick();
    wrValid = 1'b0; wrSupervisor = 1'b0; wrOp = 2'd3;
  endtask

  // drive a lookup right after an edge, sample 3 time units later
  task automatic look(input logic [31:0] va, input logic wr);
    lookupValid = 1'b1; lookupVaddr = va; lookupWrite = wr;
    #3;
  endtask

  task automatic idle();
    tick();
    lookupValid = 1'b0; lookupWrite = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick(); rstN = 1'b1; tick();
    // R8 reset state
    chk("R8 faultPending", 32'(faultPending), 0);
    chk("R8 faultVpn", 32'(faultVpn), 0);
    chk("R8 privFault", 32'(privFault), 0);
    chk("R9 idle hit", 32'(hit), 0);
    chk("R9 idle miss", 32'(missExc), 0);
    look(32'h0000_0000, 1'b0);
    chk("R8 empty array miss", 32'(missExc), 1);
    chk("R8 empty array hit", 32'(hit), 0);
    idle();
    faultRead = 1'b1; tick(); faultRead = 1'b0;

    // R6 install entries (idx3 duplicates idx0's tag)
    entryOp(1'b1, 2'd0, 4'd0, 20'h00010, 20'h0ABCD, 1'b1);
    entryOp(1'b1, 2'd0, 4'd1, 20'h12345, 20'h54321, 1'b0);
    entryOp(1'b1, 2'd0, 4'd2, 20'hFFFFF, 20'h00001, 1'b1);
    entryOp(1'b1, 2'd0, 4'd3, 20'h00010, 20'h11111, 1'b0);

    // R1 R2 R4 R5 vector table
    for (int i = 0; i < NVEC; i++) begin
      look(VEC[i][68:37], VEC[i][36]);
      chk("R1 hit", 32'(hit), 32'(VEC[i][35]));
      chk("R2 miss", 32'(missExc), 32'(VEC[i][34]));
      chk("R4 modify", 32'(modifyExc), 32'(VEC[i][33]));
      chk("R5 multiHit", 32'(multiHit), 32'(VEC[i][32]));
      if (VEC[i][35]) chk("R1 paddr", paddr, VEC[i][31:0]);
      idle();
    end
    faultRead = 1'b1; tick(); faultRead = 1'b0;

    // R9 lookupValid low with hitting address
    lookupValid = 1'b0; lookupVaddr = 32'h1234_5000; lookupWrite = 1'b1; #3;
    chk("R9 hit gated", 32'(hit), 0);
    chk("R9 modify gated", 32'(modifyExc), 0);
    lookupWrite = 1'b0;

    // R3 latch, hold, overwrite, clear, priority
    tick(); look(32'hABCD_E000, 1'b0); idle();
    chk("R3 faultVpn latched", 32'(faultVpn), 32'hABCDE);
    chk("R3 pending set", 32'(faultPending), 1);
    tick(); tick();
    chk("R3 held", 32'(faultVpn), 32'hABCDE);
    look(32'h1234_5010, 1'b1); idle();
    chk("R3 modify overwrites", 32'(faultVpn), 32'h12345);
    faultRead = 1'b1; tick(); faultRead = 1'b0;
    chk("R3 read clears vpn", 32'(faultVpn), 0);
    chk("R3 read clears pending", 32'(faultPending), 0);
    faultRead = 1'b1; look(32'h7777_7000, 1'b0); idle(); faultRead = 1'b0;
    chk("R3 fault beats read", 32'(faultVpn), 32'h77777);
    chk("R3 fault beats read pending", 32'(faultPending), 1);
    faultRead = 1'b1; tick(); faultRead = 1'b0;

    // R7 user-mode install refused
    entryOp(1'b0, 2'd0, 4'd5, 20'h22222, 20'h33333, 1'b1);
    chk("R7 privFault", 32'(privFault), 1);
    look(32'h2222_2000, 1'b0);
    chk("R7 no install", 32'(missExc), 1);
    idle();
    chk("R7 privFault one cycle", 32'(privFault), 0);
    entryOp(1'b0, 2'd2, 4'd0, 20'h0, 20'h0, 1'b0);
    look(32'hFFFF_F000, 1'b0);
    chk("R7 user inv-all ignored", 32'(hit), 1);
    idle();
    faultRead = 1'b1; tick(); faultRead = 1'b0;

    // R6 invalidate one, reserved op, invalidate all
    entryOp(1'b1, 2'd1, 4'd1, 20'h0, 20'h0, 1'b0);
    look(32'h1234_5000, 1'b0);
    chk("R6 inv one miss", 32'(missExc), 1);
    idle();
    entryOp(1'b1, 2'd1, 4'd0, 20'h0, 20'h0, 1'b0);
    look(32'h0001_0ABC, 1'b1);
    chk("R5 next match paddr", paddr, 32'h1111_1ABC);
    chk("R5 single match", 32'(multiHit), 0);
    chk("R4 clean write", 32'(modifyExc), 1);
    idle();
    entryOp(1'b1, 2'd3, 4'd2, 20'h0, 20'h0, 1'b0);
    look(32'hFFFF_F000, 1'b0);
    chk("R6 op3 no effect", 32'(hit), 1);
    idle();
    entryOp(1'b1, 2'd2, 4'd0, 20'h0, 20'h0, 1'b0);
    look(32'hFFFF_F000, 1'b0);
    chk("R6 inv all", 32'(missExc), 1);
    idle();
    look(32'h0001_0000, 1'b0);
    chk("R6 inv all idx3", 32'(hit), 0);
    idle();
    chk("R7 supervisor no fault", 32'(privFault), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule